// File: doc/BRIEF.md
# In-Order Retire Control Unit

This block keeps track of instructions that have been dispatched to an out-of-order back end but not yet retired. It holds a circular buffer of slots. Each dispatched instruction takes one token, and that token claims as many consecutive slots as the instruction has micro-ops. When an instruction reaches write-back, an executed notification marks its token. Each cycle the oldest tokens that carry the executed mark retire in program order, up to a configurable number per cycle. Their slots then go back to the free pool.

Dispatch logic reads `rsv_ready` to learn whether the micro-op count on `rsv_uops` still fits. It then presents the request and keeps the returned token id, which it later hands back on the executed port. The retire lanes report the instruction index of every token that leaves the buffer in a given cycle, with lane 0 always the oldest. Register commit and operand storage belong elsewhere.

Top module: `rcu_retire_ctrl`

## Requirements
- R1: After reset the buffer is empty: `free_slots` equals NSLOT, `empty` is 1, `full` is 0, no retire lane is valid, and `rsv_token` is 0.
- R2: A request asks for a clamped count of slots. A micro-op count of 0 counts as 1, and a count above NSLOT counts as NSLOT. `rsv_ready` is 1 exactly when `free_slots` is at least the clamped count. A request is taken when `rsv_valid` and `rsv_ready` are both 1. In the next cycle `free_slots` is lower by the clamped count.
- R3: `rsv_token` shows the slot position where the next token will be placed, and it is 0 after reset. Each accepted request moves this position forward by the clamped count, wrapping modulo NSLOT.
- R4: An executed notification whose id names the start slot of a live token sets that token's executed mark. The token can retire from the next cycle onward.
- R5: Tokens retire strictly in the order they were reserved. Retirement halts at the oldest token that lacks the executed mark, even when younger tokens have it. Lane 0 carries the oldest retiring token, and lane k carries the k-th next one.
- R6: At most RETIRE_MAX tokens retire per cycle, and a RETIRE_MAX of 0 puts no limit on the count. The retire lanes that are valid always form a contiguous run starting at lane 0.
- R7: A retiring token hands back its whole clamped slot count at the clock edge that ends its retire cycle. The new count shows on `free_slots` in the next cycle.
- R8: If an executed notification names a position where no live token starts, `exe_reject` is 1 in that same cycle and no state changes.
- R9: `full` is 1 exactly when `free_slots` is 0. `empty` is 1 exactly when `free_slots` equals NSLOT.
- R10: A reservation and a retirement may happen in the same cycle. Availability is judged on the free count before that cycle's retirement. The next free count is the old count, minus the reserved slots, plus the retired slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_index | input | IDX_W | Instruction index stored in the new token |
| rsv_uops | input | UOP_W | Micro-op count of the instruction |
| rsv_ready | output | 1 | Clamped request fits in the free slots |
| rsv_token | output | TOK_W | Token id given to an accepted request |
| exe_valid | input | 1 | Executed notification |
| exe_token | input | TOK_W | Token id that reached write-back |
| exe_reject | output | 1 | Notification named no live token |
| ret_valid | output | LANES | Per-lane retire strobe, lane 0 oldest |
| ret_index | output | LANES*IDX_W | Instruction index per retire lane |
| free_slots | output | CNT_W | Number of unreserved slots |
| full | output | 1 | No free slot |
| empty | output | 1 | All slots free |

## Verification
The most delicate overlap is a reservation and a retirement landing in the same cycle. That cycle both consumes and returns slots, and availability must be judged on the count from before the retirement. The bench sets this up by first filling the buffer and marking the head token executed. It then presents a request while the head token's retire strobe is showing: once with a free count of zero, where the request must be refused, and once with room, where it must be granted. The result is judged by the refusal itself and by the free count in the following cycle, which must equal the old count minus the reserved slots plus the returned slots. A reference queue in the bench checks every retire lane, token id and status flag in every cycle around these events.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  // Slot count actually claimed for a micro-op count: at least one, at most the buffer.
  function automatic int unsigned rcu_clamp(int unsigned req, int unsigned nslot);
    if (req == 0) return 1;
    if (req > nslot) return nslot;
    return req;
  endfunction

  // Circular advance; step never exceeds nslot and pos stays below nslot.
  function automatic int unsigned rcu_wrap(int unsigned pos, int unsigned step,
                                           int unsigned nslot);
    int unsigned s;
    s = pos + step;
    return (s >= nslot) ? s - nslot : s;
  endfunction

endpackage

// File: rtl/rcu_alloc.sv
module rcu_alloc #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned UOP_W = 5,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned TOK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [UOP_W-1:0] req_uops,
  input  logic [CNT_W-1:0] freed,
  output logic             ready_o,
  output logic             grant_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TOK_W-1:0] tail_o,
  output logic [CNT_W-1:0] free_o
);
  import rcu_pkg::*;

  logic [CNT_W-1:0] free_q, free_d;
  logic [TOK_W-1:0] tail_q, tail_d;
  logic             upd_en;

  always_comb begin
    cnt_o   = CNT_W'(rcu_clamp(32'(req_uops), NSLOT));
    ready_o = (free_q >= cnt_o);
    grant_o = req_valid && ready_o;
    free_d  = free_q - (grant_o ? cnt_o : '0) + freed;
    tail_d  = grant_o ? TOK_W'(rcu_wrap(32'(tail_q), 32'(cnt_o), NSLOT)) : tail_q;
    upd_en  = grant_o || (freed != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= CNT_W'(NSLOT);
      tail_q <= '0;
    end else if (upd_en) begin
      free_q <= free_d;
      tail_q <= tail_d;
    end
  end

  assign tail_o = tail_q;
  assign free_o = free_q;

endmodule

// File: rtl/rcu_slot_store.sv
module rcu_slot_store #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned TOK_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [TOK_W-1:0]            wr_pos,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [CNT_W-1:0]            wr_cnt,
  input  logic [NSLOT-1:0]            clr_mask,
  input  logic                        exe_en,
  input  logic [TOK_W-1:0]            exe_pos,
  output logic [NSLOT-1:0]            vld_o,
  output logic [NSLOT-1:0]            exd_o,
  output logic [NSLOT-1:0][IDX_W-1:0] idx_o,
  output logic [NSLOT-1:0][CNT_W-1:0] cnt_o
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic             wr_hit, exe_hit;
    logic             vld_q, vld_d, exd_q, exd_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
      wr_hit  = wr_en && (32'(wr_pos) == s);
      exe_hit = exe_en && (32'(exe_pos) == s);
      if (wr_hit) begin
        vld_d = 1'b1;
        exd_d = 1'b0;
      end else if (clr_mask[s]) begin
        vld_d = 1'b0;
        exd_d = 1'b0;
      end else begin
        vld_d = vld_q;
        exd_d = exd_q | (exe_hit & vld_q);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        exd_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        exd_q <= exd_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q <= '0;
        cnt_q <= '0;
      end else if (wr_hit) begin
        idx_q <= wr_idx;
        cnt_q <= wr_cnt;
      end
    end

    assign vld_o[s] = vld_q;
    assign exd_o[s] = exd_q;
    assign idx_o[s] = idx_q;
    assign cnt_o[s] = cnt_q;
  end

endmodule

// File: rtl/rcu_retire_walk.sv
module rcu_retire_walk #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned LANES = 2,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned TOK_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_W-1:0]            used_i,
  input  logic [NSLOT-1:0]            vld_i,
  input  logic [NSLOT-1:0]            exd_i,
  input  logic [NSLOT-1:0][IDX_W-1:0] idx_i,
  input  logic [NSLOT-1:0][CNT_W-1:0] cnt_i,
  output logic [LANES-1:0]            ret_valid_o,
  output logic [LANES-1:0][IDX_W-1:0] ret_idx_o,
  output logic [NSLOT-1:0]            clr_o,
  output logic [CNT_W-1:0]            freed_o
);
  import rcu_pkg::*;

  logic [TOK_W-1:0] head_q, head_d;
  int unsigned      pos, cum;
  logic             go, take;
  logic [TOK_W-1:0] p;

  // Walk from the oldest token; each lane hops over the slots of the one before.
  always_comb begin
    pos         = 32'(head_q);
    cum         = 0;
    go          = 1'b1;
    take        = 1'b0;
    p           = head_q;
    clr_o       = '0;
    ret_valid_o = '0;
    ret_idx_o   = '0;
    for (int l = 0; l < LANES; l++) begin
      p    = TOK_W'(pos);
      take = go && vld_i[p] && exd_i[p] && (cum < 32'(used_i));
      if (take) begin
        ret_valid_o[l] = 1'b1;
        ret_idx_o[l]   = idx_i[p];
        clr_o[p]       = 1'b1;
        cum            = cum + 32'(cnt_i[p]);
        pos            = rcu_wrap(pos, 32'(cnt_i[p]), NSLOT);
      end else begin
        go = 1'b0;
      end
    end
    freed_o = CNT_W'(cum);
    head_d  = TOK_W'(pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head_q <= '0;
    else if (ret_valid_o[0]) head_q <= head_d;
  end

endmodule

// File: rtl/rcu_retire_ctrl.sv
module rcu_retire_ctrl #(
  parameter int unsigned NSLOT      = 16,
  parameter int unsigned RETIRE_MAX = 2,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned UOP_W      = 5,
  parameter int unsigned TOK_W      = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  parameter int unsigned CNT_W      = $clog2(NSLOT + 1),
  parameter int unsigned LANES      = (RETIRE_MAX == 0 || RETIRE_MAX > NSLOT) ? NSLOT : RETIRE_MAX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rsv_valid,
  input  logic [IDX_W-1:0]       rsv_index,
  input  logic [UOP_W-1:0]       rsv_uops,
  output logic                   rsv_ready,
  output logic [TOK_W-1:0]       rsv_token,
  input  logic                   exe_valid,
  input  logic [TOK_W-1:0]       exe_token,
  output logic                   exe_reject,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*IDX_W-1:0] ret_index,
  output logic [CNT_W-1:0]       free_slots,
  output logic                   full,
  output logic                   empty
);

  logic                        grant;
  logic [CNT_W-1:0]            req_cnt, freed, free_cnt, used;
  logic [NSLOT-1:0]            vld, exd, clr;
  logic [NSLOT-1:0][IDX_W-1:0] s_idx;
  logic [NSLOT-1:0][CNT_W-1:0] s_cnt;
  logic [LANES-1:0][IDX_W-1:0] lane_idx;
  logic                        tok_live;

  rcu_alloc #(.NSLOT(NSLOT), .UOP_W(UOP_W), .CNT_W(CNT_W), .TOK_W(TOK_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(rsv_valid), .req_uops(rsv_uops),
    .freed(freed), .ready_o(rsv_ready), .grant_o(grant), .cnt_o(req_cnt),
    .tail_o(rsv_token), .free_o(free_cnt)
  );

  always_comb begin
    tok_live   = (32'(exe_token) < NSLOT) && vld[exe_token];
    exe_reject = exe_valid && !tok_live;
    used       = CNT_W'(NSLOT) - free_cnt;
  end

  rcu_slot_store #(.NSLOT(NSLOT), .IDX_W(IDX_W), .CNT_W(CNT_W), .TOK_W(TOK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(grant), .wr_pos(rsv_token), .wr_idx(rsv_index),
    .wr_cnt(req_cnt), .clr_mask(clr), .exe_en(exe_valid && tok_live),
    .exe_pos(exe_token), .vld_o(vld), .exd_o(exd), .idx_o(s_idx), .cnt_o(s_cnt)
  );

  rcu_retire_walk #(.NSLOT(NSLOT), .LANES(LANES), .IDX_W(IDX_W), .CNT_W(CNT_W),
                    .TOK_W(TOK_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .used_i(used), .vld_i(vld), .exd_i(exd),
    .idx_i(s_idx), .cnt_i(s_cnt), .ret_valid_o(ret_valid), .ret_idx_o(lane_idx),
    .clr_o(clr), .freed_o(freed)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ret_index[l*IDX_W +: IDX_W] = lane_idx[l];
  end

  assign free_slots = free_cnt;
  assign full       = (free_cnt == '0);
  assign empty      = (free_cnt == CNT_W'(NSLOT));

endmodule

// File: rtl/rcu_retire_ctrl_chk.sv
module rcu_retire_ctrl_chk #(
  parameter int unsigned NSLOT      = 16,
  parameter int unsigned RETIRE_MAX = 2,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned UOP_W      = 5,
  parameter int unsigned TOK_W      = 4,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned LANES      = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rsv_valid,
  input logic [IDX_W-1:0]       rsv_index,
  input logic [UOP_W-1:0]       rsv_uops,
  input logic                   rsv_ready,
  input logic [TOK_W-1:0]       rsv_token,
  input logic                   exe_valid,
  input logic [TOK_W-1:0]       exe_token,
  input logic                   exe_reject,
  input logic [LANES-1:0]       ret_valid,
  input logic [LANES*IDX_W-1:0] ret_index,
  input logic [CNT_W-1:0]       free_slots,
  input logic                   full,
  input logic                   empty
);
  import rcu_pkg::*;

  // R2: a ready request always fits in the free slots
  a_r2_ready_fits: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_ready |-> (32'(free_slots) >= rcu_clamp(32'(rsv_uops), NSLOT)));

  // R2: a granted request with no retirement lowers the free count by its clamped size
  a_r2_free_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && rsv_ready && ret_valid == '0) |=>
      (32'(free_slots) == 32'($past(free_slots)) - rcu_clamp(32'($past(rsv_uops)), NSLOT)));

  // R3: token position advances by the clamped size, wrapping
  a_r3_token_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && rsv_ready) |=>
      (32'(rsv_token) == rcu_wrap(32'($past(rsv_token)),
                                  rcu_clamp(32'($past(rsv_uops)), NSLOT), NSLOT)));

  // R7: a retirement without a reservation raises the free count
  a_r7_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rsv_valid && rsv_ready) && ret_valid != '0) |=> (free_slots > $past(free_slots)));

  // R8: nothing is live in an empty buffer
  a_r8_empty_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && exe_valid) |-> exe_reject);

  // R9: a full buffer refuses every request
  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !rsv_ready);

  // R9: an empty buffer has nothing to retire
  a_r9_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (ret_valid == '0));

  // R6: valid lanes form a run from lane 0
  for (genvar l = 1; l < LANES; l++) begin : g_pre
    a_r6_lane_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[l] |-> ret_valid[l-1]);
  end

endmodule

bind rcu_retire_ctrl rcu_retire_ctrl_chk #(
  .NSLOT(NSLOT), .RETIRE_MAX(RETIRE_MAX), .IDX_W(IDX_W), .UOP_W(UOP_W),
  .TOK_W(TOK_W), .CNT_W(CNT_W), .LANES(LANES)
) u_chk (.*);

// File: tb/sim_rcu_retire_ctrl.sv
module sim_rcu_retire_ctrl;
  localparam int NS = 16, RM = 2, LN = 2, IW = 8, UW = 5, TW = 4, CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rsv_valid = 1'b0, exe_valid = 1'b0;
  logic [IW-1:0] rsv_index = '0;
  logic [UW-1:0] rsv_uops = '0;
  logic [TW-1:0] exe_token = '0;
  logic          rsv_ready, exe_reject, full, empty;
  logic [TW-1:0] rsv_token;
  logic [LN-1:0] ret_valid;
  logic [LN*IW-1:0] ret_index;
  logic [CW-1:0] free_slots;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rcu_retire_ctrl #(.NSLOT(NS), .RETIRE_MAX(RM), .IDX_W(IW), .UOP_W(UW)) u0 (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_index(rsv_index),
    .rsv_uops(rsv_uops), .rsv_ready(rsv_ready), .rsv_token(rsv_token),
    .exe_valid(exe_valid), .exe_token(exe_token), .exe_reject(exe_reject),
    .ret_valid(ret_valid), .ret_index(ret_index), .free_slots(free_slots),
    .full(full), .empty(empty)
  );

  // scoreboard: tokens in program order
  int q_tok[$], q_idx[$], q_n[$];
  bit q_exe[$];
  int mfree = NS, mtail = 0;

  function automatic int clampu(int u);
    if (u == 0) return 1;
    if (u > NS) return NS;
    return u;
  endfunction

  function automatic int exp_k();
    int k = 0;
    while (k < q_tok.size() && k < LN && q_exe[k]) k++;
    return k;
  endfunction

  function automatic bit is_live(int t);
    foreach (q_tok[i]) if (q_tok[i] == t) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model update at the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      q_tok.delete(); q_idx.delete(); q_n.delete(); q_exe.delete();
      mfree = NS; mtail = 0;
    end else begin
      int k, rel, n;
      bit rdy;
      k = exp_k();
      rel = 0;
      for (int i = 0; i < k; i++) rel += q_n[i];
      if (exe_valid)
        foreach (q_tok[i]) if (q_tok[i] == int'(exe_token)) q_exe[i] = 1;
      n = clampu(int'(rsv_uops));
      rdy = (mfree >= n);
      for (int i = 0; i < k; i++) begin
        void'(q_tok.pop_front()); void'(q_idx.pop_front());
        void'(q_n.pop_front()); void'(q_exe.pop_front());
      end
      if (rsv_valid && rdy) begin
        q_tok.push_back(mtail); q_idx.push_back(int'(rsv_index));
        q_n.push_back(n); q_exe.push_back(0);
        mtail = (mtail + n) % NS;
        mfree = mfree - n;
      end
      mfree = mfree + rel;
    end
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      k = exp_k();
      chk(rsv_ready == (mfree >= clampu(int'(rsv_uops))), "R2 ready", rsv_ready, mfree >= clampu(int'(rsv_uops)));
      chk(int'(rsv_token) == mtail, "R3 token", rsv_token, mtail);
      chk(int'(free_slots) == mfree, "R7 free", free_slots, mfree);
      chk(full == (mfree == 0), "R9 full", full, mfree == 0);
      chk(empty == (mfree == NS), "R9 empty", empty, mfree == NS);
      chk(exe_reject == (exe_valid && !is_live(int'(exe_token))), "R8 reject",
          exe_reject, exe_valid && !is_live(int'(exe_token)));
      for (int l = 0; l < LN; l++) begin
        chk(ret_valid[l] == (l < k), "R6 lane valid", ret_valid[l], l < k);
        if (l < k)
          chk(int'(ret_index[l*IW +: IW]) == q_idx[l], "R5 order",
              ret_index[l*IW +: IW], q_idx[l]);
      end
    end
  end

  task automatic drive(bit rv, int ridx, int ru, bit ev, int et);
    rsv_valid = rv; rsv_index = IW'(ridx); rsv_uops = UW'(ru);
    exe_valid = ev; exe_token = TW'(et);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    rsv_valid = 0; exe_valid = 0; rsv_uops = '0;
  endtask

  task automatic step(bit rv, int ridx, int ru, bit ev, int et);
    drive(rv, ridx, ru, ev, et);
    tick();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(empty == 1, "R1 empty", empty, 1);
    chk(full == 0, "R1 full", full, 0);
    chk(int'(free_slots) == NS, "R1 free", free_slots, NS);
    chk(ret_valid == '0, "R1 retire", ret_valid, 0);
    chk(rsv_token == '0, "R1 token", rsv_token, 0);
    @(posedge clk); #1;

    step(1, 10, 1, 0, 0);
    step(1, 11, 3, 0, 0);
    step(1, 12, 2, 0, 0);
    @(negedge clk);
    chk(int'(free_slots) == 10, "R2 free after three", free_slots, 10);
    chk(int'(rsv_token) == 6, "R3 tail", rsv_token, 6);
    @(posedge clk); #1;

    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 4);
    @(negedge clk);
    chk(ret_valid == '0, "R5 head not executed", ret_valid, 0);
    @(posedge clk); #1;
    step(0, 0, 0, 1, 0);
    @(negedge clk);
    chk(ret_valid == 2'b11, "R4 head executed retires", ret_valid, 3);
    chk(int'(ret_index[IW-1:0]) == 10, "R5 lane0 oldest", ret_index[IW-1:0], 10);
    repeat (3) tick();

    // R8 notification for a slot inside a retired token
    drive(0, 0, 0, 1, 2);
    @(negedge clk);
    chk(exe_reject == 1, "R8 reject", exe_reject, 1);
    tick();
    @(negedge clk);
    chk(int'(free_slots) == NS && ret_valid == '0, "R8 no effect", free_slots, NS);
    @(posedge clk); #1;

    // R2 oversize clamp, R9 full
    step(1, 20, 31, 0, 0);
    drive(1, 77, 1, 0, 0);
    @(negedge clk);
    chk(full == 1, "R9 full after clamp", full, 1);
    chk(rsv_ready == 0, "R9 full refuses", rsv_ready, 0);
    tick();
    step(0, 0, 0, 1, 6);
    repeat (2) tick();
    @(negedge clk);
    chk(empty == 1, "R7 all slots back", empty, 1);
    @(posedge clk); #1;

    // R2 zero micro-ops count as one
    step(1, 21, 0, 0, 0);
    @(negedge clk);
    chk(int'(free_slots) == NS - 1, "R2 zero clamps to one", free_slots, NS - 1);
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) step(1, 30 + i, 1, 0, 0);
    for (int t = 11; t >= 7; t--) step(0, 0, 0, 1, t);
    @(negedge clk);
    chk(ret_valid == '0, "R5 younger executed wait", ret_valid, 0);
    @(posedge clk); #1;
    step(0, 0, 0, 1, 6);
    @(negedge clk);
    chk(ret_valid == 2'b11, "R6 limit two", ret_valid, 3);
    @(posedge clk); #1;
    repeat (3) tick();

    // R10 reserve and retire in one cycle
    step(1, 40, 8, 0, 0);
    step(1, 41, 8, 0, 0);
    step(0, 0, 0, 1, 12);
    drive(1, 99, 2, 0, 0);
    @(negedge clk);
    chk(ret_valid[0] == 1 && rsv_ready == 0, "R10 judged before retire", rsv_ready, 0);
    tick();
    step(1, 42, 8, 1, 4);
    tick();
    step(0, 0, 0, 1, 12);
    drive(1, 43, 3, 0, 0);
    @(negedge clk);
    chk(ret_valid[0] == 1 && rsv_ready == 1, "R10 grant with retire", rsv_ready, 1);
    tick();
    @(negedge clk);
    chk(int'(free_slots) == 13, "R10 free net", free_slots, 13);
    @(posedge clk); #1;
    step(0, 0, 0, 1, 4);
    repeat (3) tick();
    @(negedge clk);
    chk(empty == 1, "R9 drained", empty, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule